// File: doc/BRIEF.md
# Two-Window Pin Control Register Block

This block holds the configuration and sampled state of 32 general-purpose pins and exposes the same storage through two address windows on one 32-bit register bus. The shared window (word offsets 0x00–0x18) may be used by both an application host and a privileged host. The restricted window (0x1C–0x3C) and the pin-ownership word are reachable only when the privilege sideband is high. Each pin has one ownership bit. It decides which window may change that pin's output value, direction, trigger level, interrupt mask and interrupt flag. Every setting exists exactly once, so handing a pin from one window to the other moves no data.

The block drives per-pin output-enable and output-value signals towards the pads. It samples the pad inputs through a two-flop synchronizer and takes a one-time snapshot of them after reset. It also keeps a sticky, level-triggered flag per pin and raises one summary interrupt per window.

Top module: `gpio_dual_view`

## Requirements
- R1: After reset every writable word is zero, `pin_oe`, `pin_out`, `irq_restricted` and `irq_shared` are low, and every flag reads zero.
- R2: A shared-window write (offsets 0x00 output, 0x04 direction, 0x0C level, 0x10 flag, 0x14 mask) changes only bits whose ownership bit is 1. A shared-window read returns 0 in every bit whose ownership bit is 0.
- R3: A restricted-window write (0x20 output, 0x24 direction, 0x2C level, 0x30 flag, 0x34 mask) changes only bits whose ownership bit is 0. A restricted-window read returns all 32 bits. Writes to enable (0x1C) and ownership (0x3C) are never masked.
- R4: An access to 0x1C–0x3C with the privilege sideband low reads zero and writes nothing. A word offset above 0x3C, or an address with either of its two low bits set, also reads zero and writes nothing.
- R5: Changing an ownership bit makes the existing setting of that pin visible at once through the window that now owns it.
- R6: `pin_oe` is high exactly for pins whose direction bit and enable bit are both 1. `pin_out` equals the output bit on such pins and is 0 elsewhere.
- R7: The input word (0x08 / 0x28) shows the pin level two clock edges after it changes, ANDed with the enable word. Writes to it are ignored.
- R8: The mirror word (0x18 / 0x38) holds the synchronized pins captured on the third rising edge after reset release. It never changes afterwards, and writes to it are ignored.
- R9: On each edge, a flag bit is set when its pin is enabled and the synchronized pin equals its level bit. Writing 1 to a flag bit through the owning window clears it unless the pin is at its level in that same cycle, in which case the bit stays 1.
- R10: `irq_restricted` is the OR of flag AND mask over pins with ownership 0. `irq_shared` is the same OR over pins with ownership 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Privilege sideband; high for the privileged host |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_oe | output | 32 | Pad drive enable per pin |
| pin_out | output | 32 | Pad output value per pin |
| irq_restricted | output | 1 | Summary interrupt of restricted-owned pins |
| irq_shared | output | 1 | Summary interrupt of shared-owned pins |

## Verification
The collision of interest is a write-one-to-clear of a flag that lands in the same cycle as the pin sitting at its trigger level: the set path and the clear path both act on the same bit at one edge. The bench holds a pin at its level, issues the clear through the owning window, and expects the flag and the window's interrupt to stay high. It then releases the pin, lets the synchronizer drain, and repeats the clear, which must now succeed. A second collision also gets a check: a clear issued through the non-owning window for a pin that is no longer at its level must leave the flag untouched.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;

  localparam int unsigned GPIO_W   = 32;
  localparam int unsigned MAP_WORDS = 16;
  localparam int unsigned CFG_N    = 4;

  typedef logic [GPIO_W-1:0] word_t;

  typedef enum logic [3:0] {
    K_OUT, K_DIR, K_IN, K_LVL, K_FLAG, K_MASK, K_MIR, K_EN, K_OWN, K_NONE
  } reg_kind_e;

  // keep bits of old where allow is 0, take new where allow is 1
  function automatic word_t merge_bits(word_t old_v, word_t new_v, word_t allow);
    return (old_v & ~allow) | (new_v & allow);
  endfunction

  // word index inside the 16-word map -> register kind
  function automatic reg_kind_e kind_of(logic [3:0] idx);
    case (idx)
      4'd0, 4'd8:  return K_OUT;
      4'd1, 4'd9:  return K_DIR;
      4'd2, 4'd10: return K_IN;
      4'd3, 4'd11: return K_LVL;
      4'd4, 4'd12: return K_FLAG;
      4'd5, 4'd13: return K_MASK;
      4'd6, 4'd14: return K_MIR;
      4'd7:        return K_EN;
      4'd15:       return K_OWN;
      default:     return K_NONE;
    endcase
  endfunction

  // which kind each owner-masked configuration slot holds
  function automatic reg_kind_e cfg_kind(int unsigned slot);
    case (slot)
      0:       return K_OUT;
      1:       return K_DIR;
      2:       return K_LVL;
      default: return K_MASK;
    endcase
  endfunction

  // pins currently sitting at their trigger level
  function automatic word_t level_hit(word_t smp, word_t lvl, word_t en);
    return en & ~(smp ^ lvl);
  endfunction

  function automatic logic any_pending(word_t flag, word_t mask, word_t sel);
    return |(flag & mask & sel);
  endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_dv_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              sh_hit,
  output logic              rs_hit,
  output logic              unpriv_hit,
  output logic              wr_sh,
  output logic              wr_rs,
  output reg_kind_e         kind
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned FIRST_RS = 7;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_map;
  logic             rs_region;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign in_map    = aligned && (32'(idx) < MAP_WORDS);
  assign rs_region = (32'(idx) >= FIRST_RS);
  assign kind      = in_map ? kind_of(idx[3:0]) : K_NONE;

  assign sh_hit     = bus_valid && in_map && !rs_region;
  assign rs_hit     = bus_valid && in_map && rs_region && bus_priv;
  assign unpriv_hit = bus_valid && in_map && rs_region && !bus_priv;
  assign wr_sh      = sh_hit && bus_write;
  assign wr_rs      = rs_hit && bus_write;

endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg
  import gpio_dv_pkg::*;
#(
  parameter reg_kind_e KIND = K_OUT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_sh,
  input  logic      wr_rs,
  input  reg_kind_e kind,
  input  word_t     wdata,
  input  word_t     owner,
  output word_t     q
);

  logic sel;
  assign sel = (kind == KIND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (sel && wr_sh) begin
      q <= merge_bits(q, wdata, owner);
    end else if (sel && wr_rs) begin
      q <= merge_bits(q, wdata, ~owner);
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_dv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t pin_in,
  output word_t sync_q,
  output word_t mirror_q,
  output logic  mirror_done
);

  word_t                  stage [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] fill;
  logic                   take_snap;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= '0;
        end else if (s == 0) begin
          stage[s] <= pin_in;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_q    = stage[SYNC_STAGES-1];
  assign take_snap = (&fill) && !mirror_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill        <= '0;
      mirror_q    <= '0;
      mirror_done <= 1'b0;
    end else begin
      fill <= {fill[SYNC_STAGES-2:0], 1'b1};
      if (take_snap) begin
        mirror_q    <= sync_q;
        mirror_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_dv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  word_t     sync_q,
  input  word_t     en_q,
  input  word_t     lvl_q,
  input  word_t     mask_q,
  input  word_t     owner_q,
  input  logic      wr_sh,
  input  logic      wr_rs,
  input  reg_kind_e kind,
  input  word_t     wdata,
  output word_t     flag_q,
  output word_t     active_set,
  output logic      irq_restricted,
  output logic      irq_shared
);

  word_t clr_req;
  logic  flag_sel;

  assign flag_sel   = (kind == K_FLAG);
  assign active_set = level_hit(sync_q, lvl_q, en_q);

  always_comb begin
    clr_req = '0;
    if (flag_sel && wr_sh) clr_req = wdata & owner_q;
    else if (flag_sel && wr_rs) clr_req = wdata & ~owner_q;
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_req) | active_set;
  end

  assign irq_restricted = any_pending(flag_q, mask_q, ~owner_q);
  assign irq_shared     = any_pending(flag_q, mask_q, owner_q);

endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
  import gpio_dv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [GPIO_W-1:0] bus_wdata,
  output logic [GPIO_W-1:0] bus_rdata,
  input  logic [GPIO_W-1:0] pin_in,
  output logic [GPIO_W-1:0] pin_oe,
  output logic [GPIO_W-1:0] pin_out,
  output logic              irq_restricted,
  output logic              irq_shared
);

  logic      sh_hit, rs_hit, unpriv_hit, wr_sh, wr_rs;
  reg_kind_e kind;

  word_t en_q, owner_q, out_q, dir_q, lvl_q, mask_q;
  word_t sync_q, mirror_q, flag_q, active_set;
  logic  mirror_done;
  word_t cfg_q [CFG_N];
  word_t view;

  // named events for the checker
  logic wr_sh_out, wr_rs_out, unpriv_wr;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_priv  (bus_priv),
    .bus_addr  (bus_addr),
    .sh_hit    (sh_hit),
    .rs_hit    (rs_hit),
    .unpriv_hit(unpriv_hit),
    .wr_sh     (wr_sh),
    .wr_rs     (wr_rs),
    .kind      (kind)
  );

  genvar g;
  generate
    for (g = 0; g < CFG_N; g++) begin : g_cfg
      gpio_masked_reg #(.KIND(cfg_kind(g))) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_sh(wr_sh),
        .wr_rs(wr_rs),
        .kind (kind),
        .wdata(bus_wdata),
        .owner(owner_q),
        .q    (cfg_q[g])
      );
    end
  endgenerate

  assign out_q  = cfg_q[0];
  assign dir_q  = cfg_q[1];
  assign lvl_q  = cfg_q[2];
  assign mask_q = cfg_q[3];

  // restricted-only words: never owner-masked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      owner_q <= '0;
    end else if (wr_rs) begin
      if (kind == K_EN)  en_q    <= bus_wdata;
      if (kind == K_OWN) owner_q <= bus_wdata;
    end
  end

  gpio_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .sync_q     (sync_q),
    .mirror_q   (mirror_q),
    .mirror_done(mirror_done)
  );

  gpio_irq_unit u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_q        (sync_q),
    .en_q          (en_q),
    .lvl_q         (lvl_q),
    .mask_q        (mask_q),
    .owner_q       (owner_q),
    .wr_sh         (wr_sh),
    .wr_rs         (wr_rs),
    .kind          (kind),
    .wdata         (bus_wdata),
    .flag_q        (flag_q),
    .active_set    (active_set),
    .irq_restricted(irq_restricted),
    .irq_shared    (irq_shared)
  );

  always_comb begin
    case (kind)
      K_OUT:   view = out_q;
      K_DIR:   view = dir_q;
      K_IN:    view = sync_q & en_q;
      K_LVL:   view = lvl_q;
      K_FLAG:  view = flag_q;
      K_MASK:  view = mask_q;
      K_MIR:   view = mirror_q;
      K_EN:    view = en_q;
      K_OWN:   view = owner_q;
      default: view = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (sh_hit)      bus_rdata = view & owner_q;
    else if (rs_hit) bus_rdata = view;
  end

  assign pin_oe  = dir_q & en_q;
  assign pin_out = out_q & pin_oe;

  assign wr_sh_out = wr_sh && (kind == K_OUT);
  assign wr_rs_out = wr_rs && (kind == K_OUT);
  assign unpriv_wr = unpriv_hit && bus_write;

endmodule

// File: rtl/gpio_dual_view_chk.sv
module gpio_dual_view_chk
  import gpio_dv_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input word_t pin_oe,
  input word_t pin_out,
  input logic  irq_restricted,
  input logic  irq_shared,
  input word_t en_q,
  input word_t owner_q,
  input word_t out_q,
  input word_t flag_q,
  input word_t active_set,
  input word_t mirror_q,
  input logic  mirror_done,
  input logic  wr_sh_out,
  input logic  wr_rs_out,
  input logic  unpriv_wr
);

  AST_SHARED_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sh_out |=> (((out_q ^ $past(out_q)) & ~$past(owner_q)) == '0)); // R2

  AST_RESTR_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rs_out |=> (((out_q ^ $past(out_q)) & $past(owner_q)) == '0)); // R3

  AST_UNPRIV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    unpriv_wr |=> ($stable(owner_q) && $stable(en_q))); // R4

  AST_PIN_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R6

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~en_q) == '0)); // R6

  AST_MIRROR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_done && $past(mirror_done)) |-> $stable(mirror_q)); // R8

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_set != '0) |=> ((flag_q & $past(active_set)) == $past(active_set))); // R9

  AST_IRQ_RS_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_restricted |-> ((flag_q & ~owner_q) != '0)); // R10

  AST_IRQ_SH_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> ((flag_q & owner_q) != '0)); // R10

endmodule

bind gpio_dual_view gpio_dual_view_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pin_oe        (pin_oe),
  .pin_out       (pin_out),
  .irq_restricted(irq_restricted),
  .irq_shared    (irq_shared),
  .en_q          (en_q),
  .owner_q       (owner_q),
  .out_q         (out_q),
  .flag_q        (flag_q),
  .active_set    (active_set),
  .mirror_q      (mirror_q),
  .mirror_done   (mirror_done),
  .wr_sh_out     (wr_sh_out),
  .wr_rs_out     (wr_rs_out),
  .unpriv_wr     (unpriv_wr)
);

// File: tb/gpio_dual_view_tb.sv
module gpio_dual_view_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_priv = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = 32'hA5A5_0F0F;
  logic [31:0] pin_oe, pin_out;
  logic        irq_restricted, irq_shared;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  gpio_dual_view u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .irq_restricted(irq_restricted), .irq_shared(irq_shared)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic p);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic p, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_priv = p;
    #(CLK_P/4);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h20, 1'b1, d); check("R1 out", d, '0);
    rd(8'h3C, 1'b1, d); check("R1 owner", d, '0);
    rd(8'h1C, 1'b1, d); check("R1 enable", d, '0);
    rd(8'h30, 1'b1, d); check("R1 flag", d, '0);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irqs", {30'd0, irq_restricted, irq_shared}, '0);
    rd(8'h38, 1'b1, d); check("R8 mirror snapshot", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_restricted_drive();
    logic [31:0] d;
    wr(8'h1C, 32'h00FF_FFFF, 1'b1);
    wr(8'h24, 32'h0000_FFFF, 1'b1);
    wr(8'h20, 32'h1234_5678, 1'b1);
    rd(8'h20, 1'b1, d); check("R3 full read", d, 32'h1234_5678);
    check("R6 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R6 pin_out", pin_out, 32'h0000_5678);
  endtask

  task automatic t_ownership();
    logic [31:0] d;
    wr(8'h3C, 32'h0000_FF00, 1'b1);
    rd(8'h00, 1'b0, d); check("R5 handed-over view", d, 32'h0000_5600);
    wr(8'h00, 32'hFFFF_FFFF, 1'b0);
    rd(8'h20, 1'b1, d); check("R2 shared write masked", d, 32'h1234_FF78);
    wr(8'h20, 32'h0000_0000, 1'b1);
    rd(8'h20, 1'b1, d); check("R3 restricted write masked", d, 32'h0000_FF00);
    check("R6 pin_out follows", pin_out, 32'h0000_FF00);
  endtask

  task automatic t_unpriv();
    logic [31:0] d;
    wr(8'h3C, 32'hFFFF_FFFF, 1'b0);
    wr(8'h1C, 32'h0000_0000, 1'b0);
    rd(8'h3C, 1'b0, d); check("R4 unpriv read zero", d, '0);
    rd(8'h3C, 1'b1, d); check("R4 owner unchanged", d, 32'h0000_FF00);
    check("R4 enable unchanged", pin_oe, 32'h0000_FFFF);
    rd(8'h40, 1'b1, d); check("R4 unmapped", d, '0);
    wr(8'h22, 32'hFFFF_FFFF, 1'b1);
    rd(8'h20, 1'b1, d); check("R4 misaligned write ignored", d, 32'h0000_FF00);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h0F00_F0F0;
    rd(8'h28, 1'b1, d); check("R7 one edge old", d, 32'h00A5_0F0F);
    rd(8'h28, 1'b1, d); check("R7 two edges new", d, 32'h0000_F0F0);
    rd(8'h08, 1'b0, d); check("R7 shared input", d, 32'h0000_F000);
    wr(8'h28, 32'h0, 1'b1);
    rd(8'h28, 1'b1, d); check("R7 write ignored", d, 32'h0000_F0F0);
    wr(8'h38, 32'h0, 1'b1);
    rd(8'h38, 1'b1, d); check("R8 mirror fixed", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    wr(8'h2C, 32'hF0FF_0F0F, 1'b1);
    wr(8'h0C, 32'hF0FF_0F0F, 1'b0);
    wr(8'h30, 32'hFFFF_FFFF, 1'b1);
    wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    rd(8'h30, 1'b1, d); check("R9 flags cleared", d, '0);
    wr(8'h34, 32'hFFFF_FFFF, 1'b1);
    wr(8'h14, 32'hFFFF_FFFF, 1'b0);
    check("R10 quiet", {30'd0, irq_restricted, irq_shared}, '0);
    // restricted pin 0 goes to its level
    @(negedge clk);
    pin_in = pin_in | 32'h1;
    rd(8'h30, 1'b1, d);
    rd(8'h30, 1'b1, d); check("R9 flag not yet", d, '0);
    rd(8'h30, 1'b1, d); check("R9 flag set", d, 32'h1);
    check("R10 restricted irq", {30'd0, irq_restricted, irq_shared}, 32'h2);
    // clear while still at level: set wins
    wr(8'h30, 32'h1, 1'b1);
    rd(8'h30, 1'b1, d); check("R9 clear blocked at level", d, 32'h1);
    pin_in = pin_in & ~32'h1;
    repeat (3) @(negedge clk);
    wr(8'h30, 32'h1, 1'b1);
    rd(8'h30, 1'b1, d); check("R9 clear after idle", d, '0);
    check("R10 restricted irq low", {31'd0, irq_restricted}, '0);
    // shared pin 8
    pin_in = pin_in | 32'h100;
    repeat (4) @(negedge clk);
    rd(8'h10, 1'b0, d); check("R9 shared flag", d, 32'h100);
    check("R10 shared irq", {30'd0, irq_restricted, irq_shared}, 32'h1);
    pin_in = pin_in & ~32'h100;
    repeat (4) @(negedge clk);
    wr(8'h30, 32'h100, 1'b1);
    rd(8'h10, 1'b0, d); check("R3 restricted clear ignored", d, 32'h100);
    wr(8'h10, 32'h100, 1'b0);
    rd(8'h10, 1'b0, d); check("R2 shared clear", d, '0);
    check("R10 shared irq low", {31'd0, irq_shared}, '0);
    // mask off
    wr(8'h14, 32'h0, 1'b0);
    pin_in = pin_in | 32'h100;
    repeat (4) @(negedge clk);
    rd(8'h10, 1'b0, d); check("R9 masked flag still set", d, 32'h100);
    check("R10 masked no irq", {31'd0, irq_shared}, '0);
    pin_in = pin_in & ~32'h100;
  endtask

  task automatic t_handover();
    logic [31:0] d;
    wr(8'h3C, 32'h0, 1'b1);
    rd(8'h00, 1'b0, d); check("R2 unowned reads zero", d, '0);
    rd(8'h20, 1'b1, d); check("R5 single copy kept", d, 32'h0000_FF00);
    wr(8'h3C, 32'hFFFF_FFFF, 1'b1);
    rd(8'h00, 1'b0, d); check("R5 visible in shared", d, 32'h0000_FF00);
    wr(8'h20, 32'hFFFF_FFFF, 1'b1);
    rd(8'h20, 1'b1, d); check("R3 all owned no change", d, 32'h0000_FF00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_restricted_drive();
    t_ownership();
    t_unpriv();
    t_input();
    t_flags();
    t_handover();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule